// File: doc/BRIEF.md
# PLL Retune Sequencer

This block retunes a frequency synthesiser to a new output rate without software stepping through the register sequence. A host holds a small table of rate settings (a rate code with the main divider M, the input pre-divider P, the output post-divider S and a fractional word K). It raises a request carrying one rate code. The sequencer finds the matching table entry and compares its dividers with the values held in the live control word. It then takes one of two paths. If the loop dividers are unchanged, it rewrites only the post-divider field. Otherwise it performs a full relock: it programs a lock-time register scaled by P, rewrites all three divider fields in one write, and waits for the lock status bit.

The block owns a single register write port (select plus data) toward the synthesiser and watches the current control and fractional words. A write lands at the clock edge that samples `reg_we`. Status read back is therefore trusted only from the following cycle, and the sequencer waits one settle cycle before polling. A programmable timeout ends a poll that never sees lock. With parameter `FRAC` set, the sequencer also compares K, uses a 9-bit M field and a lock factor of 3000, and writes K to the fractional word right after the control word. The default build is the integer variant.

Top module: `pll_retune_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `reg_we` are all low.
- R2: A request whose code matches no entry with its valid bit set ends with `done` and `err` high together one cycle after the lookup cycle, and no register write is issued.
- R3: When the selected M and P equal bits 25:16 and 13:8 of the current control word, exactly one write with select 1 (control word) is issued. It changes only bits 2:0 to the new S, `done` rises in the same cycle, and `busy` is high for a single cycle.
- R4: On a full change, the first write uses select 0 (lock time) with data P×270. It comes in the cycle before the control word write.
- R5: On a full change, the control word write carries M in bits 25:16, P in bits 13:8 and S in bits 2:0. Every other bit keeps the value read from the current word.
- R6: After a full change, `done` rises without `err` only once bit 29 of the control word reads set. Polling starts two cycles after the control word write.
- R7: If lock is not seen, the request ends with `done` and `err` after `tmo_limit`+1 poll cycles. `busy` is then high for `tmo_limit`+4 cycles in total.
- R8: A request raised while `busy` is high is ignored: it neither changes the result in progress nor starts a second sequence.
- R9: `done` is a single-cycle pulse, and `err` is never high without `done`.
- R10: Table entries are written through the table port at index `tbl_idx`. An entry written with its valid bit clear never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a retune (sampled while idle) |
| req_code | input | CODE_W | Rate code to look up |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with `done` |
| tmo_limit | input | TMO_W | Lock poll limit in cycles |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | IDX_W | Table entry index |
| tbl_valid | input | 1 | Valid bit stored with the entry |
| tbl_code | input | CODE_W | Rate code of the entry |
| tbl_m | input | 10 | Main divider of the entry |
| tbl_p | input | 6 | Pre-divider of the entry |
| tbl_s | input | 3 | Post-divider of the entry |
| tbl_k | input | 16 | Fractional word of the entry |
| pll_ctrl_rd | input | 32 | Current control word, lock status in bit 29 |
| pll_frac_rd | input | 32 | Current fractional word |
| reg_we | output | 1 | Register write strobe |
| reg_sel | output | 2 | Write target: 0 lock time, 1 control, 2 fractional |
| reg_wdata | output | 32 | Write data |

## Verification
The bench targets two cases. The first is a request that changes only S against one that changes only M or only P. A design comparing the wrong fields would either relock needlessly or skip a required relock and leave the loop unlocked. The second is a post-divider request issued while the loop is still unlocked after a timeout. It must take the short path and not wait. The bench also checks the largest P for the lock-time product, bit preservation outside the divider fields, the exact poll length on timeout, and invalidated table entries. It checks a request pulsed mid-sequence too. A design that re-latches the code there would report a spurious miss.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;
  localparam int WORD_W   = 32;
  localparam int M_LSB    = 16;
  localparam int MTAB_W   = 10;
  localparam int P_LSB    = 8;
  localparam int P_W      = 6;
  localparam int S_LSB    = 0;
  localparam int S_W      = 3;
  localparam int K_W      = 16;
  localparam int LOCK_BIT = 29;

  typedef enum logic [1:0] {
    SEL_LOCK = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_FRAC = 2'd2
  } wsel_e;

  typedef struct packed {
    logic [MTAB_W-1:0] m;
    logic [P_W-1:0]    p;
    logic [S_W-1:0]    s;
    logic [K_W-1:0]    k;
  } pms_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIND,
    ST_WCTRL,
    ST_WFRAC,
    ST_SETTLE,
    ST_POLL
  } st_e;
endpackage

// File: rtl/pllseq_table.sv
module pllseq_table
  import pllseq_pkg::*;
#(
  parameter int N      = 8,
  parameter int CODE_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [CODE_W-1:0] wr_code,
  input  pms_t              wr_set,
  input  logic [CODE_W-1:0] look_code,
  output logic              hit,
  output pms_t              hit_set
);
  logic              vld_q  [N];
  logic [CODE_W-1:0] code_q [N];
  pms_t              set_q  [N];
  logic [N-1:0]      match;

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vld_q[g] <= 1'b0;
      else if (ent_en) vld_q[g] <= wr_valid;
    end

    always_ff @(posedge clk) begin
      if (ent_en) begin
        code_q[g] <= wr_code;
        set_q[g]  <= wr_set;
      end
    end

    assign match[g] = vld_q[g] && (code_q[g] == look_code);
  end

  // Lowest index wins when codes repeat.
  always_comb begin
    hit     = |match;
    hit_set = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) hit_set = set_q[i];
    end
  end
endmodule

// File: rtl/pllseq_wordgen.sv
module pllseq_wordgen
  import pllseq_pkg::*;
#(
  parameter bit FRAC = 1'b0
) (
  input  logic [WORD_W-1:0] cur_ctrl,
  input  logic [WORD_W-1:0] cur_frac,
  input  pms_t              set,
  output logic              same_loop,
  output logic [WORD_W-1:0] sonly_word,
  output logic [WORD_W-1:0] full_word,
  output logic [WORD_W-1:0] frac_word,
  output logic [WORD_W-1:0] lock_time
);
  localparam int M_W      = FRAC ? 9 : 10;
  localparam int LOCK_MUL = FRAC ? 3000 : 270;
  localparam logic [WORD_W-1:0] M_MASK = WORD_W'(((1 << M_W) - 1) << M_LSB);
  localparam logic [WORD_W-1:0] P_MASK = WORD_W'(((1 << P_W) - 1) << P_LSB);
  localparam logic [WORD_W-1:0] S_MASK = WORD_W'(((1 << S_W) - 1) << S_LSB);

  logic mp_same;
  logic k_same;

  assign mp_same = (cur_ctrl[M_LSB +: M_W] == set.m[M_W-1:0]) &&
                   (cur_ctrl[P_LSB +: P_W] == set.p);

  if (FRAC) begin : g_frac
    assign k_same = (cur_frac[K_W-1:0] == set.k);
  end else begin : g_int
    assign k_same = 1'b1;
  end

  assign same_loop = mp_same && k_same;

  assign sonly_word = (cur_ctrl & ~S_MASK) | (WORD_W'(set.s) << S_LSB);

  assign full_word = (cur_ctrl & ~(M_MASK | P_MASK | S_MASK))
                   | (WORD_W'(set.m[M_W-1:0]) << M_LSB)
                   | (WORD_W'(set.p) << P_LSB)
                   | (WORD_W'(set.s) << S_LSB);

  assign frac_word = {cur_frac[WORD_W-1:K_W], set.k};

  assign lock_time = WORD_W'(set.p) * WORD_W'(LOCK_MUL);
endmodule

// File: rtl/pllseq_ctrl.sv
module pllseq_ctrl
  import pllseq_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int TMO_W  = 16,
  parameter bit FRAC   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [CODE_W-1:0] req_code,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              tbl_hit,
  input  pms_t              tbl_set,
  input  logic              same_loop,
  input  logic [WORD_W-1:0] sonly_word,
  input  logic [WORD_W-1:0] full_word,
  input  logic [WORD_W-1:0] frac_word,
  input  logic [WORD_W-1:0] lock_time,
  input  logic              lock_stat,
  output logic [CODE_W-1:0] look_code,
  output pms_t              act_set,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              reg_we,
  output logic [1:0]        reg_sel,
  output logic [WORD_W-1:0] reg_wdata
);
  st_e               st_q, st_d;
  logic [CODE_W-1:0] code_q, code_d;
  pms_t              set_q;
  logic              set_en;
  logic [TMO_W-1:0]  cnt_q, cnt_d;
  logic              we_q, we_d;
  wsel_e             sel_q, sel_d;
  logic [WORD_W-1:0] wd_q, wd_d;
  logic              done_q, done_d;
  logic              err_q, err_d;

  always_comb begin
    st_d   = st_q;
    code_d = code_q;
    cnt_d  = cnt_q;
    we_d   = 1'b0;
    sel_d  = sel_q;
    wd_d   = wd_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    set_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req) begin
          code_d = req_code;
          st_d   = ST_FIND;
        end
      end
      ST_FIND: begin
        if (!tbl_hit) begin
          done_d = 1'b1;
          err_d  = 1'b1;
          st_d   = ST_IDLE;
        end else if (same_loop) begin
          we_d   = 1'b1;
          sel_d  = SEL_CTRL;
          wd_d   = sonly_word;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          set_en = 1'b1;
          we_d   = 1'b1;
          sel_d  = SEL_LOCK;
          wd_d   = lock_time;
          st_d   = ST_WCTRL;
        end
      end
      ST_WCTRL: begin
        we_d  = 1'b1;
        sel_d = SEL_CTRL;
        wd_d  = full_word;
        if (FRAC) st_d = ST_WFRAC;
        else      st_d = ST_SETTLE;
      end
      ST_WFRAC: begin
        we_d  = 1'b1;
        sel_d = SEL_FRAC;
        wd_d  = frac_word;
        st_d  = ST_SETTLE;
      end
      ST_SETTLE: begin
        cnt_d = '0;
        st_d  = ST_POLL;
      end
      ST_POLL: begin
        if (lock_stat) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else if (cnt_q == tmo_limit) begin
          done_d = 1'b1;
          err_d  = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      we_q   <= 1'b0;
      sel_q  <= SEL_LOCK;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      we_q   <= we_d;
      sel_q  <= sel_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    code_q <= code_d;
    cnt_q  <= cnt_d;
    wd_q   <= wd_d;
    if (set_en) set_q <= tbl_set;
  end

  assign look_code = code_q;
  assign act_set   = (st_q == ST_FIND) ? tbl_set : set_q;
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign reg_we    = we_q;
  assign reg_sel   = sel_q;
  assign reg_wdata = wd_q;
endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
  import pllseq_pkg::*;
#(
  parameter int N_ENT   = 8,
  parameter int CODE_W  = 8,
  parameter int TMO_W   = 16,
  parameter bit FRAC    = 1'b0,
  localparam int IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [CODE_W-1:0] req_code,
  output logic              busy,
  output logic              done,
  output logic              err,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic              tbl_valid,
  input  logic [CODE_W-1:0] tbl_code,
  input  logic [9:0]        tbl_m,
  input  logic [5:0]        tbl_p,
  input  logic [2:0]        tbl_s,
  input  logic [15:0]       tbl_k,
  input  logic [31:0]       pll_ctrl_rd,
  input  logic [31:0]       pll_frac_rd,
  output logic              reg_we,
  output logic [1:0]        reg_sel,
  output logic [31:0]       reg_wdata
);
  pms_t              wr_set;
  pms_t              hit_set;
  pms_t              act_set;
  logic              hit;
  logic [CODE_W-1:0] look_code;
  logic              same_loop;
  logic [WORD_W-1:0] sonly_word, full_word, frac_word, lock_time;

  assign wr_set = '{m: tbl_m, p: tbl_p, s: tbl_s, k: tbl_k};

  pllseq_table #(.N(N_ENT), .CODE_W(CODE_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (tbl_we),
    .wr_idx    (tbl_idx),
    .wr_valid  (tbl_valid),
    .wr_code   (tbl_code),
    .wr_set    (wr_set),
    .look_code (look_code),
    .hit       (hit),
    .hit_set   (hit_set)
  );

  pllseq_wordgen #(.FRAC(FRAC)) u_wordgen (
    .cur_ctrl   (pll_ctrl_rd),
    .cur_frac   (pll_frac_rd),
    .set        (act_set),
    .same_loop  (same_loop),
    .sonly_word (sonly_word),
    .full_word  (full_word),
    .frac_word  (frac_word),
    .lock_time  (lock_time)
  );

  pllseq_ctrl #(.CODE_W(CODE_W), .TMO_W(TMO_W), .FRAC(FRAC)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .req_code   (req_code),
    .tmo_limit  (tmo_limit),
    .tbl_hit    (hit),
    .tbl_set    (hit_set),
    .same_loop  (same_loop),
    .sonly_word (sonly_word),
    .full_word  (full_word),
    .frac_word  (frac_word),
    .lock_time  (lock_time),
    .lock_stat  (pll_ctrl_rd[LOCK_BIT]),
    .look_code  (look_code),
    .act_set    (act_set),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata)
  );
endmodule

// File: rtl/pllseq_chk.sv
module pllseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       reg_we,
  input logic [1:0] reg_sel,
  input logic       lock_bit
);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  a_r4_lock_then_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd0) |=> (reg_we && reg_sel == 2'd1));

  a_r2_no_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> !reg_we);

  a_r3_short_write_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (done && reg_we) |-> (reg_sel == 2'd1 && !err));

  a_r6_lock_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && !reg_we) |-> $past(lock_bit));

  a_r8_end_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind pll_retune_seq pllseq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .reg_we   (reg_we),
  .reg_sel  (reg_sel),
  .lock_bit (pll_ctrl_rd[29])
);

// File: tb/pll_retune_seq_tb_top.sv
`timescale 1ns/1ps
module pll_retune_seq_tb_top;
  localparam int TMO = 40;
  localparam logic [31:0] DIV_MASK = 32'h03FF_3F07;
  localparam logic [31:0] RST_WORD = 32'hE400_C0F8;

  localparam logic [7:0] T_CODE [8] = '{8'h10, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77};
  localparam logic [9:0] T_M    [8] = '{10'd200, 10'd200, 10'd300, 10'd100, 10'd1023, 10'd300, 10'd301, 10'd9};
  localparam logic [5:0] T_P    [8] = '{6'd3, 6'd3, 6'd4, 6'd63, 6'd1, 6'd5, 6'd5, 6'd2};
  localparam logic [2:0] T_S    [8] = '{3'd1, 3'd2, 3'd0, 3'd7, 3'd3, 3'd0, 3'd0, 3'd4};
  localparam logic       T_V    [8] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};

  // {code, entry index, lock delay, kind}; kind 0 full, 1 short, 2 miss, 3 timeout
  localparam int NV = 12;
  localparam logic [21:0] VECS [NV] = '{
    {8'h10, 4'd0, 8'd5,   2'd0},
    {8'h11, 4'd1, 8'd0,   2'd1},
    {8'h22, 4'd2, 8'd1,   2'd0},
    {8'h55, 4'd5, 8'd7,   2'd0},
    {8'h66, 4'd6, 8'd3,   2'd0},
    {8'h66, 4'd6, 8'd0,   2'd1},
    {8'h33, 4'd3, 8'd10,  2'd0},
    {8'h44, 4'd4, 8'd2,   2'd0},
    {8'h77, 4'd7, 8'd0,   2'd2},
    {8'h99, 4'd0, 8'd0,   2'd2},
    {8'h10, 4'd0, 8'd255, 2'd3},
    {8'h11, 4'd1, 8'd0,   2'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [7:0]  req_code = '0;
  logic        busy, done, err;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_idx = '0;
  logic        tbl_valid = 1'b0;
  logic [7:0]  tbl_code = '0;
  logic [9:0]  tbl_m = '0;
  logic [5:0]  tbl_p = '0;
  logic [2:0]  tbl_s = '0;
  logic [15:0] tbl_k = '0;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;

  logic [31:0] m_ctrl, m_lock;
  int          lock_cnt, lock_dly, wr_seq, lock_seq, ctrl_seq, n_wr;
  int          n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  pll_retune_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_code(req_code),
    .busy(busy), .done(done), .err(err), .tmo_limit(16'(TMO)),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_valid(tbl_valid),
    .tbl_code(tbl_code), .tbl_m(tbl_m), .tbl_p(tbl_p), .tbl_s(tbl_s),
    .tbl_k(tbl_k), .pll_ctrl_rd(m_ctrl), .pll_frac_rd(32'h0),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata)
  );

  // Synthesiser model: writes land at the sampling edge; a loop change drops lock.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= RST_WORD; m_lock <= '0; lock_cnt <= 0;
      wr_seq <= 0; lock_seq <= 0; ctrl_seq <= 0; n_wr <= 0;
    end else if (reg_we) begin
      n_wr   <= n_wr + 1;
      wr_seq <= wr_seq + 1;
      if (reg_sel == 2'd0) begin
        m_lock <= reg_wdata; lock_seq <= wr_seq;
      end else if (reg_sel == 2'd1) begin
        ctrl_seq <= wr_seq;
        if (reg_wdata[25:16] != m_ctrl[25:16] || reg_wdata[13:8] != m_ctrl[13:8]) begin
          m_ctrl   <= {reg_wdata[31:30], 1'b0, reg_wdata[28:0]};
          lock_cnt <= lock_dly;
        end else begin
          m_ctrl <= {reg_wdata[31:30], m_ctrl[29], reg_wdata[28:0]};
        end
      end
    end else if (!m_ctrl[29] && lock_dly != 255) begin
      if (lock_cnt <= 1) m_ctrl[29] <= 1'b1;
      else lock_cnt <= lock_cnt - 1;
    end
  end

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic tbl_write(input int idx, input bit v, input logic [7:0] c,
                           input logic [9:0] m, input logic [5:0] p, input logic [2:0] s);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 3'(idx); tbl_valid = v; tbl_code = c;
    tbl_m = m; tbl_p = p; tbl_s = s; tbl_k = '0;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic wait_done(output bit e, output int bcyc);
    int guard = 0;
    bcyc = 0;
    while (!done) begin
      if (busy) bcyc++;
      @(negedge clk);
      guard++;
      if (guard > 5000) begin
        check(1'b0, "R6 watchdog", 32'(guard), 32'd0);
        finish_run();
      end
    end
    e = err;
    @(negedge clk);
    check(!done, "R9 done pulse", 32'(done), 32'd0);
  endtask

  task automatic run_req(input logic [7:0] c, output bit e, output int bcyc);
    @(negedge clk);
    req = 1'b1; req_code = c;
    @(negedge clk);
    req = 1'b0;
    wait_done(e, bcyc);
  endtask

  initial begin
    #(200000 * 4);
    check(1'b0, "R6 global watchdog", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    bit e;
    int bc, n0;
    logic [31:0] pre, expw;
    lock_dly = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !err && !reg_we, "R1 reset state",
          {28'd0, busy, done, err, reg_we}, 32'd0);

    for (int i = 0; i < 8; i++) tbl_write(i, T_V[i], T_CODE[i], T_M[i], T_P[i], T_S[i]);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] c;
      int ix, kd;
      c  = VECS[v][21:14];
      ix = int'(VECS[v][13:10]);
      lock_dly = int'(VECS[v][9:2]);
      kd = int'(VECS[v][1:0]);
      pre = m_ctrl;
      n0  = n_wr;
      run_req(c, e, bc);
      expw = (pre & ~DIV_MASK) | {6'd0, T_M[ix], 2'd0, T_P[ix], 5'd0, T_S[ix]};
      case (kd)
        0: begin
          check(!e, "R6 full change no error", 32'(e), 32'd0);
          check(n_wr - n0 == 2, "R4 two writes", 32'(n_wr - n0), 32'd2);
          check(m_lock == 32'(T_P[ix]) * 32'd270, "R4 lock time", m_lock, 32'(T_P[ix]) * 32'd270);
          check(lock_seq < ctrl_seq, "R4 lock before ctrl", 32'(lock_seq), 32'(ctrl_seq));
          check((m_ctrl & ~32'h2000_0000) == (expw & ~32'h2000_0000), "R5 control word",
                m_ctrl, expw);
          check(m_ctrl[29], "R6 locked at done", 32'(m_ctrl[29]), 32'd1);
        end
        1: begin
          expw = {pre[31:3], T_S[ix]};
          check(!e, "R3 short path no error", 32'(e), 32'd0);
          check(n_wr - n0 == 1, "R3 single write", 32'(n_wr - n0), 32'd1);
          check(m_ctrl == expw, "R3 only S changed", m_ctrl, expw);
          check(bc == 1, "R3 no lock wait", 32'(bc), 32'd1);
        end
        2: begin
          check(e, "R2 miss flagged", 32'(e), 32'd1);
          check(n_wr == n0, "R2 no write", 32'(n_wr - n0), 32'd0);
          check(m_ctrl == pre, "R10 invalid entry unmatched", m_ctrl, pre);
        end
        default: begin
          check(e, "R7 timeout flagged", 32'(e), 32'd1);
          check(bc == TMO + 4, "R7 timeout length", 32'(bc), 32'(TMO + 4));
          check(n_wr - n0 == 2, "R7 writes before poll", 32'(n_wr - n0), 32'd2);
        end
      endcase
    end

    // R8: a request pulsed mid-sequence is ignored
    lock_dly = 4;
    n0 = n_wr;
    @(negedge clk);
    req = 1'b1; req_code = 8'h22;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    req = 1'b1; req_code = 8'h99;
    @(negedge clk);
    req = 1'b0;
    wait_done(e, bc);
    check(!e, "R8 result unchanged", 32'(e), 32'd0);
    check(m_ctrl[25:16] == 10'd300, "R8 first request applied", 32'(m_ctrl[25:16]), 32'd300);
    repeat (5) begin
      @(negedge clk);
      check(!busy && n_wr - n0 == 2, "R8 no second sequence", 32'(n_wr - n0), 32'd2);
    end

    // R10: rewrite an entry valid, then invalidate another
    tbl_write(7, 1'b1, 8'h77, 10'd9, 6'd2, 3'd4);
    lock_dly = 2;
    run_req(8'h77, e, bc);
    check(!e && m_ctrl[25:16] == 10'd9 && m_ctrl[13:8] == 6'd2, "R10 rewritten entry used",
          m_ctrl, 32'h0009_0200);
    tbl_write(0, 1'b0, 8'h10, 10'd200, 6'd3, 3'd1);
    pre = m_ctrl;
    run_req(8'h10, e, bc);
    check(e && m_ctrl == pre, "R10 cleared entry misses", m_ctrl, pre);

    finish_run();
  end
endmodule